// File: doc/BRIEF.md
# Indexed Peripheral Clock Control Register

This block gives software one 32-bit control word for the clock settings of up to 64 peripherals. Each write carries a peripheral number. When the write is a command, it also carries a new enable bit and a 2-bit divide code, and these are stored for that peripheral. When the write is not a command, it stores nothing and only chooses which peripheral the read port reports. The read port always shows the chosen peripheral's number, its stored enable bit and its stored divide code.

From the shared master clock, the block produces one clock-enable strobe per peripheral. An enabled peripheral whose divide code is `d` gets one strobe every 2^d master cycles, which gives divide-by-1, 2, 4 or 8. A disabled peripheral gets no strobe. Peripherals 0 and 1 are fixed: they are always enabled, they always run at the full master rate, and command writes to them are ignored. The divider counter of a peripheral restarts at every command write to that peripheral, so the first strobe after a reconfiguration comes at a known cycle.

Top module: `pclk_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configurable peripheral (number 2 and up) is disabled with divide code 0, and peripheral 0 is selected. The read value is therefore 0x1000_0000.
- R2: Field positions in both the write and the read word: peripheral number in bits 5:0, command flag in bit 12, divide code in bits 17:16, enable in bit 28. All other bits are ignored on write and read as 0.
- R3: A write with bit 12 set to a peripheral numbered 2 or higher stores that write's enable bit and divide code for that peripheral.
- R4: A write with bit 12 clear changes no stored setting and no strobe pattern. It only selects the peripheral that the read port reports.
- R5: From the cycle after any write, the read port shows the written peripheral number, that peripheral's stored enable and divide code, and bit 12 as 0.
- R6: Peripherals 0 and 1 always read as enabled with divide code 0 and strobe on every cycle. Command writes to them have no effect.
- R7: An enabled peripheral with divide code d strobes exactly once in every 2^d consecutive cycles, at a regular spacing.
- R8: A disabled peripheral never strobes. A command write with enable 0 stops the strobe from the next cycle.
- R9: A command write to a peripheral restarts its divider. When the new setting is enabled with code d, the first strobe comes in the 2^d-th cycle after the write edge, and no strobe comes before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written |
| rd_data | output | 32 | Settings of the selected peripheral |
| clk_en_o | output | 64 | Per-peripheral divided clock-enable strobes |

## Verification
Two things can fall on the same edge: a command write to a peripheral, and that peripheral's divider reaching its terminal count. The write must win, and the counter must return to zero rather than wrap or produce a strobe. The bench provokes this by issuing rewrites at arbitrary offsets while the peripheral's counter is running. A behavioural model that keeps per-peripheral integer counters is compared against all 64 strobes and the read word on every cycle, so a write that lands on a strobe cycle is judged by the exact cycles in which the strobe reappears.

// File: rtl/pclk_pkg.sv
// Shared field positions of the peripheral clock control word.
// Assumes a 32-bit register; positions are fixed by the software view.
package pclk_pkg;
    localparam int REG_W   = 32;
    localparam int ID_LSB  = 0;
    localparam int CMD_POS = 12;
    localparam int DIV_LSB = 16;
    localparam int EN_POS  = 28;
endpackage

// File: rtl/pclk_cmd_decode.sv
// Splits a written control word into its fields and decides whether the
// write updates stored settings. Assumes fields never overlap.
module pclk_cmd_decode
    import pclk_pkg::*;
#(
    parameter int ID_W      = 6,
    parameter int DIV_W     = 2,
    parameter int FIXED_IDS = 2
) (
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic              cmd_hit,
    output logic              sel_load,
    output logic [ID_W-1:0]   wr_id,
    output logic              wr_enable,
    output logic [DIV_W-1:0]  wr_div
);
    logic cmd_flag;
    logic unused_rsvd;

    // Field extraction from the written word.
    always_comb begin
        wr_id     = wr_data[ID_LSB +: ID_W];
        wr_div    = wr_data[DIV_LSB +: DIV_W];
        wr_enable = wr_data[EN_POS];
        cmd_flag  = wr_data[CMD_POS];
    end

    // A command counts only for configurable peripherals.
    always_comb begin
        sel_load = wr_en;
        cmd_hit  = wr_en && cmd_flag && (wr_id >= ID_W'(FIXED_IDS));
    end

    // Reserved bits are accepted and dropped.
    assign unused_rsvd = ^{wr_data[REG_W-1:EN_POS+1], wr_data[EN_POS-1:DIV_LSB+DIV_W],
                           wr_data[DIV_LSB-1:CMD_POS+1], wr_data[CMD_POS-1:ID_LSB+ID_W]};
endmodule

// File: rtl/pclk_cfg_store.sv
// Per-peripheral enable/divide storage, selection register and read mux.
// Assumes the lowest FIXED_IDS peripherals are hard-wired enabled at /1.
module pclk_cfg_store
    import pclk_pkg::*;
#(
    parameter int ID_W      = 6,
    parameter int DIV_W     = 2,
    parameter int FIXED_IDS = 2,
    localparam int NUM      = 1 << ID_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_hit,
    input  logic                      sel_load,
    input  logic [ID_W-1:0]           wr_id,
    input  logic                      wr_enable,
    input  logic [DIV_W-1:0]          wr_div,
    output logic [NUM-1:0]            en_vec,
    output logic [NUM-1:0][DIV_W-1:0] div_arr,
    output logic [NUM-1:0]            restart_vec,
    output logic [REG_W-1:0]          rd_data
);
    logic [ID_W-1:0] sel_q;

    for (genvar p = 0; p < NUM; p++) begin : g_slot
        if (p < FIXED_IDS) begin : g_fixed
            // Fixed slot: constant settings, never restarted.
            assign en_vec[p]      = 1'b1;
            assign div_arr[p]     = '0;
            assign restart_vec[p] = 1'b0;
        end else begin : g_cfg
            logic             en_q;
            logic [DIV_W-1:0] div_q;
            logic             hit;
            assign hit = cmd_hit && (wr_id == ID_W'(p));
            // Store settings on a command write addressed here.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q  <= 1'b0;
                    div_q <= '0;
                end else if (hit) begin
                    en_q  <= wr_enable;
                    div_q <= wr_div;
                end
            end
            assign en_vec[p]      = en_q;
            assign div_arr[p]     = div_q;
            assign restart_vec[p] = hit;
        end
    end

    // Selection follows every write, command or not.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= '0;
        else if (sel_load) sel_q <= wr_id;
    end

    // Read word assembled from the selected slot; command bit reads zero.
    always_comb begin
        rd_data                      = '0;
        rd_data[ID_LSB +: ID_W]      = sel_q;
        rd_data[DIV_LSB +: DIV_W]    = div_arr[sel_q];
        rd_data[EN_POS]              = en_vec[sel_q];
    end
endmodule

// File: rtl/pclk_div_unit.sv
// One peripheral's power-of-two divider producing a clock-enable strobe.
// Assumes the counter spans the largest divide; a restart zeroes it.
module pclk_div_unit #(
    parameter int DIV_W = 2,
    localparam int CNT_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Free-running count while enabled, held at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (enable)  cnt_q <= cnt_q + 1'b1;
        else              cnt_q <= '0;
    end

    // Terminal mask has div low bits set.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(div));
    end

    // Strobe when all masked bits are ones.
    assign pulse = enable && ((cnt_q & mask) == mask);
endmodule

// File: rtl/pclk_ctrl.sv
// Top of the indexed peripheral clock control register: decode, storage
// and one divider per peripheral. Assumes one write port, no wait states.
module pclk_ctrl
    import pclk_pkg::*;
#(
    parameter int ID_W      = 6,
    parameter int DIV_W     = 2,
    parameter int FIXED_IDS = 2,
    localparam int NUM      = 1 << ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [NUM-1:0]   clk_en_o
);
    logic                      cmd_hit;
    logic                      sel_load;
    logic [ID_W-1:0]           wr_id;
    logic                      wr_enable;
    logic [DIV_W-1:0]          wr_div;
    logic [NUM-1:0]            en_vec;
    logic [NUM-1:0][DIV_W-1:0] div_arr;
    logic [NUM-1:0]            restart_vec;

    pclk_cmd_decode #(.ID_W(ID_W), .DIV_W(DIV_W), .FIXED_IDS(FIXED_IDS)) u_dec (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cmd_hit   (cmd_hit),
        .sel_load  (sel_load),
        .wr_id     (wr_id),
        .wr_enable (wr_enable),
        .wr_div    (wr_div)
    );

    pclk_cfg_store #(.ID_W(ID_W), .DIV_W(DIV_W), .FIXED_IDS(FIXED_IDS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_hit     (cmd_hit),
        .sel_load    (sel_load),
        .wr_id       (wr_id),
        .wr_enable   (wr_enable),
        .wr_div      (wr_div),
        .en_vec      (en_vec),
        .div_arr     (div_arr),
        .restart_vec (restart_vec),
        .rd_data     (rd_data)
    );

    for (genvar p = 0; p < NUM; p++) begin : g_div
        pclk_div_unit #(.DIV_W(DIV_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (en_vec[p]),
            .div     (div_arr[p]),
            .restart (restart_vec[p]),
            .pulse   (clk_en_o[p])
        );
    end
endmodule

// File: rtl/pclk_ctrl_chk.sv
// Port-level properties of pclk_ctrl, bound onto every instance.
// Assumes default field positions from pclk_pkg.
module pclk_ctrl_chk
    import pclk_pkg::*;
#(
    parameter int ID_W      = 6,
    parameter int DIV_W     = 2,
    parameter int FIXED_IDS = 2,
    localparam int NUM      = 1 << ID_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic [NUM-1:0]   clk_en_o
);
    logic [ID_W-1:0]  last_id;
    logic [REG_W-1:0] field_mask;
    logic             is_cfg_id;

    // Remember the most recently written peripheral number.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_id <= '0;
        else if (wr_en) last_id <= wr_data[ID_LSB +: ID_W];
    end

    // Mask of bits that may be nonzero on the read port.
    always_comb begin
        field_mask                   = '0;
        field_mask[ID_LSB +: ID_W]   = '1;
        field_mask[DIV_LSB +: DIV_W] = '1;
        field_mask[EN_POS]           = 1'b1;
    end

    assign is_cfg_id = wr_data[ID_LSB +: ID_W] >= ID_W'(FIXED_IDS);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~field_mask) == '0); // R2

    AST_CMD_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[CMD_POS] && is_cfg_id |=>
            rd_data[EN_POS] == $past(wr_data[EN_POS]) &&
            rd_data[DIV_LSB +: DIV_W] == $past(wr_data[DIV_LSB +: DIV_W])); // R3

    AST_NOCMD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[CMD_POS] &&
        wr_data[ID_LSB +: ID_W] == rd_data[ID_LSB +: ID_W] |=>
            $stable(rd_data)); // R4

    AST_SELECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[ID_LSB +: ID_W] == $past(wr_data[ID_LSB +: ID_W])
                  && !rd_data[CMD_POS]); // R5

    AST_FIXED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        &clk_en_o[FIXED_IDS-1:0]); // R6

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[CMD_POS] && !wr_data[EN_POS] && is_cfg_id |=>
            !clk_en_o[last_id]); // R8

    AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[CMD_POS] && wr_data[DIV_LSB +: DIV_W] != '0 && is_cfg_id |=>
            !clk_en_o[last_id]); // R9
endmodule

bind pclk_ctrl pclk_ctrl_chk #(.ID_W(ID_W), .DIV_W(DIV_W), .FIXED_IDS(FIXED_IDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .clk_en_o (clk_en_o)
);

// File: tb/pclk_ctrl_test.sv
`timescale 1ns/1ps
module pclk_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [63:0] clk_en_o;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    int m_en  [64];
    int m_div [64];
    int m_cnt [64];
    int m_sel;

    always #4 clk = ~clk;

    pclk_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .clk_en_o (clk_en_o)
    );

    function automatic logic [31:0] word(int en, int dv, int id);
        logic [31:0] w;
        w = '0;
        w[28] = en[0];
        w[17:16] = dv[1:0];
        w[5:0] = id[5:0];
        return w;
    endfunction

    // Reference model advances on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 64; p++) begin
                m_en[p] = 0; m_div[p] = 0; m_cnt[p] = 0;
            end
            m_sel = 0;
        end else begin
            for (int p = 0; p < 64; p++) begin
                if (wr_en && wr_data[12] && int'(wr_data[5:0]) == p && p >= 2) begin
                    m_en[p] = int'(wr_data[28]);
                    m_div[p] = int'(wr_data[17:16]);
                    m_cnt[p] = 0;
                end else if (m_en[p] != 0) m_cnt[p] = (m_cnt[p] + 1) % 8;
                else m_cnt[p] = 0;
            end
            if (wr_en) m_sel = int'(wr_data[5:0]);
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [63:0] exp_en;
            logic [31:0] exp_rd;
            for (int p = 0; p < 64; p++) begin
                int per;
                per = 1 << m_div[p];
                exp_en[p] = (p < 2) ? 1'b1 : (m_en[p] != 0 && (m_cnt[p] % per) == per - 1);
            end
            exp_rd = (m_sel < 2) ? word(1, 0, m_sel) : word(m_en[m_sel], m_div[m_sel], m_sel);
            checks++;
            if (clk_en_o !== exp_en) begin
                errors++;
                $display("FAIL R7 strobes: actual %h expected %h", clk_en_o, exp_en);
            end
            checks++;
            if (rd_data !== exp_rd) begin
                errors++;
                $display("FAIL R5 read word: actual %h expected %h", rd_data, exp_rd);
            end
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write on a negedge; returns at the negedge after the write edge.
    task automatic wr(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic count(int p, int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (clk_en_o[p]) c++;
            @(negedge clk);
        end
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", 64'(rd_data), 64'h1000_0000);
        check("R1", clk_en_o, 64'h3);

        // R3 command store and R7 rate at /4
        wr(word(1, 2, 5) | 32'h1000);
        check("R3", 64'(rd_data), 64'(word(1, 2, 5)));
        count(5, 64, c);
        check("R7 div4", 64'(c), 64'd16);

        wr(word(1, 0, 9) | 32'h1000);
        count(9, 64, c);
        check("R7 div1", 64'(c), 64'd64);
        wr(word(1, 3, 10) | 32'h1000);
        count(10, 64, c);
        check("R7 div8", 64'(c), 64'd8);

        // R4 non-command write selects only
        wr(word(0, 0, 5));
        check("R4", 64'(rd_data), 64'(word(1, 2, 5)));
        count(5, 64, c);
        check("R4 strobes", 64'(c), 64'd16);

        // R5 command bit reads zero after a command write
        wr(word(1, 1, 11) | 32'h1000);
        check("R5", 64'(rd_data[12]), 64'd0);

        // R8 disable
        wr(word(0, 2, 5) | 32'h1000);
        count(5, 32, c);
        check("R8", 64'(c), 64'd0);

        // R6 fixed peripheral ignores command
        wr(word(0, 3, 0) | 32'h1000);
        check("R6", 64'(rd_data), 64'(word(1, 0, 0)));
        count(0, 16, c);
        check("R6 strobes", 64'(c), 64'd16);

        // R2 reserved bits ignored
        wr(word(1, 1, 7) | 32'h1000 | 32'hE00C_EFC0);
        check("R2", 64'(rd_data), 64'(word(1, 1, 7)));

        // R9 restart at several offsets
        for (int k = 0; k < 5; k++) begin
            repeat (k + 1) @(negedge clk);
            wr(word(1, 3, 10) | 32'h1000);
            for (int j = 1; j <= 8; j++) begin
                check("R9", 64'(clk_en_o[10]), (j == 8) ? 64'd1 : 64'd0);
                @(negedge clk);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule